// File: doc/BRIEF.md
# PWM Action Qualifier

This block turns timing events from a PWM time base into two raw output levels, `pwmA` and `pwmB`. Two event pulses come from the time base: counter-at-zero and counter-at-period. Alongside them come the counter value and a direction flag. The block holds two compare registers and detects matches against the counter itself. Each match is tagged by the count direction, so every output sees six distinct event kinds.

A 12-bit action table belongs to each output. It assigns a 2-bit action to every event kind: no action, drive low, drive high or invert. Software can override the table in two ways. A one-shot force applies an action exactly once. A continuous force pins the output to a level for as long as it is selected. Both compare registers can be written directly or through a shadow copy. The shadow copy is committed to the active register when the counter passes zero.

Top module: `aq_top`

## Requirements
- R1: While `rstN` is low, both outputs and both compare registers (active and shadow) are 0.
- R2: Action codes are 00 = none, 01 = drive low, 10 = drive high, 11 = invert. In each 12-bit table, bits [1:0] serve the zero event, [3:2] the period event, [5:4] compare A counting up, [7:6] compare A counting down, [9:8] compare B counting up, and [11:10] compare B counting down.
- R3: A compare event occurs in a cycle where `cnt` equals that compare register's active value. It counts as an up event when `countUp` is 1 and as a down event when `countUp` is 0.
- R4: When several hardware events with non-zero actions occur in one cycle, the one applied is compare B, else compare A, else period, else zero. Events whose code is 00 do not block lower-priority events.
- R5: `pwmA` acts only on `actCfgA`, and `pwmB` acts only on `actCfgB`.
- R6: A one-shot strobe with a non-zero action code is applied once, replacing any hardware action in that cycle. A one-shot with code 00 has no effect.
- R7: `contForce` code 01 holds the output low and code 10 holds it high, overriding one-shot and hardware actions. Codes 00 and 11 disable the force. After release, the output keeps its level until the next action.
- R8: With `shadowEn` = 0, a compare write changes the active value at the next edge.
- R9: With `shadowEn` = 1, a compare write goes to the shadow copy. The active value takes the shadow value at each edge where `evZero` is high.
- R10: Every action takes effect at the clock edge that samples its cause, so the output changes one cycle after its inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evZero | input | 1 | Counter-at-zero event pulse |
| evPeriod | input | 1 | Counter-at-period event pulse |
| countUp | input | 1 | 1 while counting up, 0 while counting down |
| cnt | input | CNT_W | Time-base counter value |
| cmpAWr | input | 1 | Write strobe for compare A |
| cmpBWr | input | 1 | Write strobe for compare B |
| cmpWrData | input | CNT_W | Compare write data |
| shadowEn | input | 1 | Route compare writes through the shadow copies |
| actCfgA | input | 12 | Action table for output A |
| actCfgB | input | 12 | Action table for output B |
| oneShotA | input | 1 | One-shot force strobe, output A |
| oneShotActA | input | 2 | One-shot action code, output A |
| oneShotB | input | 1 | One-shot force strobe, output B |
| oneShotActB | input | 2 | One-shot action code, output B |
| contForceA | input | 2 | Continuous force code, output A |
| contForceB | input | 2 | Continuous force code, output B |
| pwmA | output | 1 | Raw PWM output A |
| pwmB | output | 1 | Raw PWM output B |

## Verification
The only state the block holds is the two output levels and the four compare registers. A wrong output level is visible on the very next cycle. A wrong active compare value stays hidden until the counter reaches the expected or the actual value. It then shows as an output edge that is missing or lands at the wrong position, one cycle after that match. A shadow value that was lost only appears after the next zero event has committed it. For that reason the stimulus sweeps the counter across the written values after each commit.

// File: rtl/aq_pkg.sv
package aq_pkg;
  typedef enum logic [1:0] {
    AQ_NONE = 2'b00,
    AQ_LOW  = 2'b01,
    AQ_HIGH = 2'b10,
    AQ_INV  = 2'b11
  } aqAct_t;

  typedef struct packed {
    logic drvHigh;
    logic drvLow;
    logic invert;
  } aqStrobe_t;

  localparam int CFG_W = 12;

  function automatic aqStrobe_t aqResolve(
    input logic [CFG_W-1:0] cfg,
    input logic evZ, input logic evP,
    input logic evAu, input logic evAd,
    input logic evBu, input logic evBd,
    input logic os, input logic [1:0] osAct,
    input logic [1:0] cont);
    aqStrobe_t st;
    logic [1:0] act;
    act = AQ_NONE;
    // lowest priority first; later hits overwrite
    if (evZ  && cfg[1:0]   != 2'b00) act = cfg[1:0];
    if (evP  && cfg[3:2]   != 2'b00) act = cfg[3:2];
    if (evAu && cfg[5:4]   != 2'b00) act = cfg[5:4];
    if (evAd && cfg[7:6]   != 2'b00) act = cfg[7:6];
    if (evBu && cfg[9:8]   != 2'b00) act = cfg[9:8];
    if (evBd && cfg[11:10] != 2'b00) act = cfg[11:10];
    if (os && osAct != 2'b00) act = osAct;
    if (cont == 2'b01) act = AQ_LOW;
    if (cont == 2'b10) act = AQ_HIGH;
    st.drvHigh = (act == AQ_HIGH);
    st.drvLow  = (act == AQ_LOW);
    st.invert  = (act == AQ_INV);
    return st;
  endfunction
endpackage

// File: rtl/aq_ctrl.sv
module aq_ctrl
  import aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   evZero,
  input  logic                   evPeriod,
  input  logic                   countUp,
  input  logic [CNT_W-1:0]       cnt,
  input  logic                   cmpAWr,
  input  logic                   cmpBWr,
  input  logic [CNT_W-1:0]       cmpWrData,
  input  logic                   shadowEn,
  input  logic [1:0][CFG_W-1:0]  actCfg,
  input  logic [1:0]             oneShot,
  input  logic [1:0][1:0]        oneShotAct,
  input  logic [1:0][1:0]        contForce,
  output aqStrobe_t [1:0]        strb
);
  logic [CNT_W-1:0] cmpAAct, cmpBAct, cmpASh, cmpBSh;
  logic matchA, matchB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpAAct <= '0;
      cmpBAct <= '0;
      cmpASh  <= '0;
      cmpBSh  <= '0;
    end else if (shadowEn) begin
      if (evZero) begin
        cmpAAct <= cmpASh;
        cmpBAct <= cmpBSh;
      end
      if (cmpAWr) cmpASh <= cmpWrData;
      if (cmpBWr) cmpBSh <= cmpWrData;
    end else begin
      if (cmpAWr) cmpAAct <= cmpWrData;
      if (cmpBWr) cmpBAct <= cmpWrData;
    end
  end

  assign matchA = (cnt == cmpAAct);
  assign matchB = (cnt == cmpBAct);

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_comb begin
      strb[ch] = aqResolve(actCfg[ch], evZero, evPeriod,
                           matchA && countUp, matchA && !countUp,
                           matchB && countUp, matchB && !countUp,
                           oneShot[ch], oneShotAct[ch], contForce[ch]);
    end

    a_r2_single_action: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({strb[ch].drvHigh, strb[ch].drvLow, strb[ch].invert}));
    a_r7_force_high: assert property (@(posedge clk) disable iff (!rstN)
      (contForce[ch] == 2'b10) |-> strb[ch].drvHigh);
  end

  a_r8_direct_write: assert property (@(posedge clk) disable iff (!rstN)
    (!shadowEn && cmpAWr) |=> cmpAAct == $past(cmpWrData));
  a_r9_shadow_commit: assert property (@(posedge clk) disable iff (!rstN)
    (shadowEn && evZero) |=> cmpBAct == $past(cmpBSh));
endmodule

// File: rtl/aq_dpath.sv
module aq_dpath
  import aq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  aqStrobe_t [1:0]  strb,
  output logic [1:0]       pwm
);
  for (genvar ch = 0; ch < 2; ch++) begin : g_out
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                pwm[ch] <= 1'b0;
      else if (strb[ch].drvHigh) pwm[ch] <= 1'b1;
      else if (strb[ch].drvLow)  pwm[ch] <= 1'b0;
      else if (strb[ch].invert)  pwm[ch] <= ~pwm[ch];
    end

    a_r1_reset_low: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rstN) |-> !pwm[ch]);
    a_r10_high_next: assert property (@(posedge clk) disable iff (!rstN)
      strb[ch].drvHigh |=> pwm[ch]);
    a_r10_low_next: assert property (@(posedge clk) disable iff (!rstN)
      strb[ch].drvLow |=> !pwm[ch]);
    a_r10_invert_next: assert property (@(posedge clk) disable iff (!rstN)
      strb[ch].invert |=> pwm[ch] != $past(pwm[ch]));
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
      !(strb[ch].drvHigh || strb[ch].drvLow || strb[ch].invert) |=> $stable(pwm[ch]));
  end
endmodule

// File: rtl/aq_top.sv
module aq_top
  import aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evZero,
  input  logic             evPeriod,
  input  logic             countUp,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cmpAWr,
  input  logic             cmpBWr,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             shadowEn,
  input  logic [11:0]      actCfgA,
  input  logic [11:0]      actCfgB,
  input  logic             oneShotA,
  input  logic [1:0]       oneShotActA,
  input  logic             oneShotB,
  input  logic [1:0]       oneShotActB,
  input  logic [1:0]       contForceA,
  input  logic [1:0]       contForceB,
  output logic             pwmA,
  output logic             pwmB
);
  aqStrobe_t [1:0] strb;
  logic [1:0]      pwm;

  aq_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .evZero(evZero), .evPeriod(evPeriod),
    .countUp(countUp), .cnt(cnt), .cmpAWr(cmpAWr), .cmpBWr(cmpBWr),
    .cmpWrData(cmpWrData), .shadowEn(shadowEn),
    .actCfg({actCfgB, actCfgA}), .oneShot({oneShotB, oneShotA}),
    .oneShotAct({oneShotActB, oneShotActA}),
    .contForce({contForceB, contForceA}), .strb(strb)
  );

  aq_dpath i_dpath (.clk(clk), .rstN(rstN), .strb(strb), .pwm(pwm));

  assign pwmA = pwm[0];
  assign pwmB = pwm[1];
endmodule

// File: tb/test_aq_top.sv
`timescale 1ns/1ps
module test_aq_top;
  logic clk = 0, rstN = 0;
  logic evZero = 0, evPeriod = 0, countUp = 0;
  logic [15:0] cnt = 16'hFFFF, cmpWrData = 0;
  logic cmpAWr = 0, cmpBWr = 0, shadowEn = 0;
  logic [11:0] actCfgA = 0, actCfgB = 0;
  logic oneShotA = 0, oneShotB = 0;
  logic [1:0] oneShotActA = 0, oneShotActB = 0, contForceA = 0, contForceB = 0;
  logic pwmA, pwmB;

  int checks = 0, fails = 0;
  string curReq = "R1";
  bit mOut[2];
  int mCmpA = 0, mCmpB = 0, mShA = 0, mShB = 0;

  always #10 clk = ~clk;

  aq_top i_aq_top (.*);

  function automatic int code(int cfg, int idx);
    return (cfg >> (2 * idx)) & 3;
  endfunction

  function automatic bit applyAct(bit cur, int act);
    if (act == 1) return 0;
    if (act == 2) return 1;
    if (act == 3) return !cur;
    return cur;
  endfunction

  task automatic modelEdge();
    int cfg[2], osAct[2], cont[2], act;
    bit os[2], mA, mB;
    if (!rstN) begin
      mOut[0] = 0; mOut[1] = 0; mCmpA = 0; mCmpB = 0; mShA = 0; mShB = 0;
      return;
    end
    cfg[0] = actCfgA; cfg[1] = actCfgB;
    os[0] = oneShotA; os[1] = oneShotB;
    osAct[0] = oneShotActA; osAct[1] = oneShotActB;
    cont[0] = contForceA; cont[1] = contForceB;
    mA = (int'(cnt) == mCmpA);
    mB = (int'(cnt) == mCmpB);
    for (int ch = 0; ch < 2; ch++) begin
      act = 0;
      if (cont[ch] == 1 || cont[ch] == 2) act = cont[ch];
      else if (os[ch] && osAct[ch] != 0) act = osAct[ch];
      else if (mB && code(cfg[ch], countUp ? 4 : 5) != 0) act = code(cfg[ch], countUp ? 4 : 5);
      else if (mA && code(cfg[ch], countUp ? 2 : 3) != 0) act = code(cfg[ch], countUp ? 2 : 3);
      else if (evPeriod && code(cfg[ch], 1) != 0) act = code(cfg[ch], 1);
      else if (evZero && code(cfg[ch], 0) != 0) act = code(cfg[ch], 0);
      mOut[ch] = applyAct(mOut[ch], act);
    end
    if (shadowEn) begin
      if (evZero) begin mCmpA = mShA; mCmpB = mShB; end
      if (cmpAWr) mShA = cmpWrData;
      if (cmpBWr) mShB = cmpWrData;
    end else begin
      if (cmpAWr) mCmpA = cmpWrData;
      if (cmpBWr) mCmpB = cmpWrData;
    end
  endtask

  task automatic compare();
    checks++;
    if (pwmA !== mOut[0]) begin
      fails++;
      $display("FAIL %s pwmA actual=%b expected=%b t=%0t", curReq, pwmA, mOut[0], $time);
    end
    checks++;
    if (pwmB !== mOut[1]) begin
      fails++;
      $display("FAIL %s pwmB actual=%b expected=%b t=%0t", curReq, pwmB, mOut[1], $time);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); modelEdge();
      @(negedge clk); compare();
      evZero = 0; evPeriod = 0; cmpAWr = 0; cmpBWr = 0; oneShotA = 0; oneShotB = 0;
    end
  endtask

  task automatic wrCmp(bit isB, int val);
    cmpWrData = val[15:0];
    if (isB) cmpBWr = 1; else cmpAWr = 1;
    cyc();
  endtask

  initial begin
    @(negedge clk);
    curReq = "R1"; cyc(3); rstN = 1; cyc(2);
    // R2: codes on zero/period fields
    curReq = "R2";
    actCfgA = 12'b0000_0000_0110; // zero: high, period: low
    evZero = 1; cyc(); evPeriod = 1; cyc();
    actCfgA = 12'b0000_0000_1100; evPeriod = 1; cyc(); evPeriod = 1; cyc();
    // R8 + R3: direct compare writes, direction split
    curReq = "R8"; shadowEn = 0; wrCmp(0, 5); wrCmp(1, 9);
    curReq = "R3";
    actCfgA = 12'b0000_0110_0000; // cmpA up: high, down: low
    countUp = 1; cnt = 5; cyc(); cnt = 6; cyc();
    countUp = 0; cnt = 5; cyc(); cnt = 4; cyc();
    // R4: all events together
    curReq = "R4";
    actCfgA = 12'b10_01_11_11_01_10; evZero = 1; evPeriod = 1; cnt = 5; countUp = 1;
    wrCmp(1, 5); cnt = 5; evZero = 1; evPeriod = 1; cyc();
    actCfgA = 12'b00_00_01_00_10_10; countUp = 1; evZero = 1; evPeriod = 1; cyc();
    actCfgA = 12'b00_00_00_00_01_10; evZero = 1; evPeriod = 1; cyc();
    actCfgA = 12'b00_00_00_00_00_11; evZero = 1; evPeriod = 1; cyc();
    // R5: independent tables
    curReq = "R5"; cnt = 16'hFFFF;
    actCfgA = 12'b0000_0000_0010; actCfgB = 12'b0000_0000_0011;
    evZero = 1; cyc(); evZero = 1; cyc(); evZero = 1; cyc();
    // R6: one-shot
    curReq = "R6";
    oneShotA = 1; oneShotActA = 2'b01; evZero = 1; cyc(); cyc();
    oneShotB = 1; oneShotActB = 2'b11; cyc();
    oneShotA = 1; oneShotActA = 2'b00; evZero = 1; cyc();
    oneShotB = 1; oneShotActB = 2'b00; cyc(2);
    // R7: continuous force
    curReq = "R7";
    contForceA = 2'b01; contForceB = 2'b10; evZero = 1; oneShotA = 1; oneShotActA = 2'b10; cyc(3);
    contForceA = 2'b11; contForceB = 2'b00; cyc(2); evZero = 1; cyc();
    contForceA = 0;
    // R9: shadow mode
    curReq = "R9"; shadowEn = 1;
    actCfgA = 12'b0000_0010_0000; actCfgB = 12'b1000_0000_0000;
    wrCmp(0, 20); wrCmp(1, 30);
    countUp = 1; cnt = 20; cyc(); countUp = 0; cnt = 30; cyc();
    evZero = 1; cnt = 0; cyc();
    countUp = 1; cnt = 20; cyc(); countUp = 0; cnt = 30; cyc();
    cmpWrData = 40; cmpAWr = 1; evZero = 1; cyc();
    cnt = 40; countUp = 1; actCfgA = 12'b0000_0011_0000; cyc(); evZero = 1; cyc(); cyc();
    // R10: random traffic, compared every cycle
    curReq = "R10";
    for (int i = 0; i < 3000; i++) begin
      evZero = ($urandom_range(0, 7) == 0); evPeriod = ($urandom_range(0, 7) == 0);
      countUp = $urandom_range(0, 1); cnt = 16'($urandom_range(0, 15));
      cmpAWr = ($urandom_range(0, 15) == 0); cmpBWr = ($urandom_range(0, 15) == 0);
      cmpWrData = 16'($urandom_range(0, 15)); shadowEn = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 31) == 0) begin
        actCfgA = 12'($urandom()); actCfgB = 12'($urandom());
      end
      oneShotA = ($urandom_range(0, 15) == 0); oneShotActA = 2'($urandom());
      oneShotB = ($urandom_range(0, 15) == 0); oneShotActB = 2'($urandom());
      contForceA = ($urandom_range(0, 15) == 0) ? 2'($urandom()) : 2'b00;
      contForceB = ($urandom_range(0, 15) == 0) ? 2'($urandom()) : 2'b00;
      cyc();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule